// File: doc/BRIEF.md
# Three-Bit-Opcode Integer ALU

This block is a purely combinational integer arithmetic and logic unit for an N-bit datapath (32 bits by default). Two operands and a three-bit function code enter; one N-bit result and a zero indicator leave in the same cycle. A single adder serves addition, subtraction and the signed-style set-less-than comparison, so the function code does double duty. Its top bit inverts the second operand, both for the bitwise gates and for the adder, and also feeds the adder's carry-in. Its low two bits pick the output from four candidates.

The unit holds no state and has no handshake. A surrounding pipeline registers its inputs and outputs as it sees fit. Because the unit never stalls, there is no back-pressure to describe: every input combination yields a defined result in the cycle it is applied.

Top module: `alu3_core`

## Requirements
- R1: Code 3'b000 drives the result to the bitwise AND of the two operands.
- R2: Code 3'b001 drives the result to the bitwise OR of the two operands.
- R3: Code 3'b010 drives the result to the sum of the operands modulo 2^N, with any carry out of the top bit discarded.
- R4: Code 3'b011 is reserved and drives the result to all zeros, whatever the operands are.
- R5: Code 3'b100 drives the result to the first operand ANDed with the bitwise complement of the second.
- R6: Code 3'b101 drives the result to the first operand ORed with the bitwise complement of the second.
- R7: Code 3'b110 drives the result to the first operand minus the second, modulo 2^N. This is formed as A + ~B + 1, so 0 - 1 gives all ones.
- R8: Code 3'b111 drives bit 0 of the result to bit N-1 of the wrapped difference A - B, and drives all higher bits to 0. For example, 25 and 32 give 1, and 32 and 25 give 0.
- R9: Under code 3'b111, the result follows the wrapped difference even when the true signed difference overflows. For example, A = 0x80000000 and B = 1 give 0, and A = 0x7FFFFFFF and B = 0xFFFFFFFF give 1.
- R10: The zero output is 1 exactly when every bit of the result is 0.
- R11: The outputs depend only on the present inputs and settle within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| fn_i | input | 3 | Function code; bit 2 inverts the second operand and sets carry-in; bits 1:0 pick the output |
| y_o | output | N | Result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
On every evaluation, the checker confirms several algebraic invariants. The reserved code and the comparison code leave all upper bits clear. An AND result is contained in both operands. An OR result covers the first operand. A difference plus the second operand gives back the first. A sum minus the second operand gives back the first. The zero output agrees with the result. The exact values of each operation, the carry and borrow wrap-around at the word edges, and the comparison's behaviour when the signed difference overflows can only be shown by the bench's directed scenarios against its own reference values.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
  // Output-select encoding: the low two function bits, in this order.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_SIGN = 2'b11
  } alu3_sel_e;

  localparam logic [2:0] FN_RESERVED = 3'b011;
  localparam int unsigned FN_W = 3;
endpackage

// File: rtl/alu3_bsel.sv
// Conditionally complements the second operand; the same control is the adder carry-in.
module alu3_bsel #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] b_i,
  input  logic         inv_i,
  output logic [N-1:0] bx_o,
  output logic         cin_o
);
  assign bx_o  = inv_i ? ~b_i : b_i;
  assign cin_o = inv_i;
endmodule

// File: rtl/alu3_adder.sv
// N-bit adder; RIPPLE picks an explicit carry chain or the inferred operator.
module alu3_adder #(
  parameter int unsigned N      = 32,
  parameter bit          RIPPLE = 1'b0
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [N-1:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
        if (i < N - 1) begin : g_cy
          assign carry[i+1] = (a_i[i] & b_i[i]) | ((a_i[i] | b_i[i]) & carry[i]);
        end
      end
    end else begin : g_infer
      localparam int unsigned PADW = N - 1;
      assign sum_o = a_i + b_i + {{PADW{1'b0}}, cin_i};
    end
  endgenerate
endmodule

// File: rtl/alu3_logic.sv
// Per-bit AND and OR of the first operand with the (possibly complemented) second.
module alu3_logic #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] bx_i,
  output logic [N-1:0] and_o,
  output logic [N-1:0] or_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_slice
      assign and_o[i] = a_i[i] & bx_i[i];
      assign or_o[i]  = a_i[i] | bx_i[i];
    end
  endgenerate
endmodule

// File: rtl/alu3_outmux.sv
// Four-way result select, with a forced-zero override for the reserved code.
module alu3_outmux
  import alu3_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  alu3_sel_e    sel_i,
  input  logic         blank_i,
  input  logic [N-1:0] and_i,
  input  logic [N-1:0] or_i,
  input  logic [N-1:0] sum_i,
  output logic [N-1:0] y_o
);
  localparam int unsigned PADW = N - 1;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  y_o = and_i;
      SEL_OR:   y_o = or_i;
      SEL_SUM:  y_o = sum_i;
      SEL_SIGN: y_o = {{PADW{1'b0}}, sum_i[N-1]};
      default:  y_o = '0;
    endcase
    if (blank_i) y_o = '0;
  end
endmodule

// File: rtl/alu3_core.sv
module alu3_core
  import alu3_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter bit          RIPPLE = 1'b0
) (
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [N-1:0]    y_o,
  output logic            zero_o
);
  logic [N-1:0] bx;
  logic         cin;
  logic [N-1:0] sum;
  logic [N-1:0] and_v;
  logic [N-1:0] or_v;
  alu3_sel_e    sel;
  logic         blank;

  assign sel   = alu3_sel_e'(fn_i[1:0]);
  assign blank = (fn_i == FN_RESERVED);

  alu3_bsel #(.N(N)) u_bsel (
    .b_i   (b_i),
    .inv_i (fn_i[2]),
    .bx_o  (bx),
    .cin_o (cin)
  );

  alu3_adder #(.N(N), .RIPPLE(RIPPLE)) u_add (
    .a_i   (a_i),
    .b_i   (bx),
    .cin_i (cin),
    .sum_o (sum)
  );

  alu3_logic #(.N(N)) u_logic (
    .a_i   (a_i),
    .bx_i  (bx),
    .and_o (and_v),
    .or_o  (or_v)
  );

  alu3_outmux #(.N(N)) u_mux (
    .sel_i   (sel),
    .blank_i (blank),
    .and_i   (and_v),
    .or_i    (or_v),
    .sum_i   (sum),
    .y_o     (y_o)
  );

  assign zero_o = ~|y_o;
endmodule

// File: rtl/alu3_core_chk.sv
module alu3_core_chk #(
  parameter int unsigned N = 32
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [2:0]   fn_i,
  input logic [N-1:0] y_o,
  input logic         zero_o
);
  always_comb begin
    // R4
    if (fn_i == 3'b011) p_reserved_blank_r4: assert (y_o == '0);
    // R8
    if (fn_i == 3'b111) p_slt_boolean_r8: assert (y_o[N-1:1] == '0);
    // R1
    if (fn_i == 3'b000) p_and_within_r1: assert (((y_o & ~a_i) | (y_o & ~b_i)) == '0);
    // R2
    if (fn_i == 3'b001) p_or_covers_r2: assert ((y_o & a_i) == a_i);
    // R5
    if (fn_i == 3'b100) p_andn_disjoint_r5: assert ((y_o & b_i) == '0);
    // R7
    if (fn_i == 3'b110) p_sub_inverse_r7: assert (N'(y_o + b_i) == a_i);
    // R3
    if (fn_i == 3'b010) p_add_inverse_r3: assert (N'(y_o - b_i) == a_i);
    // R10
    p_zero_agrees_r10: assert (zero_o == (y_o == '0));
  end
endmodule

bind alu3_core alu3_core_chk #(.N(N)) u_alu3_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .fn_i   (fn_i),
  .y_o    (y_o),
  .zero_o (zero_o)
);

// File: tb/alu3_core_bench.sv
module alu3_core_bench;
  localparam int unsigned N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  a = '0;
  logic [N-1:0]  b = '0;
  logic [2:0]    fn = 3'b000;
  logic [N-1:0]  y;
  logic          zero;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  alu3_core #(.N(N)) u_alu3_core (
    .a_i    (a),
    .b_i    (b),
    .fn_i   (fn),
    .y_o    (y),
    .zero_o (zero)
  );

  function automatic logic [N-1:0] ref_y(input logic [N-1:0] x, input logic [N-1:0] z,
                                         input logic [2:0] f);
    logic [N-1:0] d;
    d = x - z;
    case (f)
      3'b000: return x & z;
      3'b001: return x | z;
      3'b010: return x + z;
      3'b100: return x & ~z;
      3'b101: return x | ~z;
      3'b110: return d;
      3'b111: return {{(N-1){1'b0}}, d[N-1]};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply on a rising edge, sample at the next falling edge.
  task automatic apply(input string req, input logic [N-1:0] x, input logic [N-1:0] z,
                       input logic [2:0] f);
    @(posedge clk);
    a = x; b = z; fn = f;
    @(negedge clk);
    check(req, y, ref_y(x, z, f));
    check({req, " zero R10"}, {{(N-1){1'b0}}, zero}, {{(N-1){1'b0}}, (ref_y(x, z, f) == '0)});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R1 idle inputs", y, '0);
    check("R10 idle zero", {{(N-1){1'b0}}, zero}, {{(N-1){1'b0}}, 1'b1});
  endtask

  task automatic t_logic;
    apply("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);
    apply("R1", 32'hFFFF_FFFF, 32'hA5A5_5A5A, 3'b000);
    apply("R2", 32'hF000_0001, 32'h0F00_0010, 3'b001);
    apply("R2", 32'h0000_0000, 32'h0000_0000, 3'b001);
    apply("R5", 32'hFFFF_0000, 32'hFF00_FF00, 3'b100);
    apply("R6", 32'h0000_000F, 32'hFFFF_FF00, 3'b101);
    apply("R6", 32'h1234_5678, 32'h0000_0000, 3'b101);
  endtask

  task automatic t_arith;
    apply("R3", 32'd1000, 32'd2345, 3'b010);
    apply("R3 wrap", 32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    apply("R3 carry", 32'h8000_0000, 32'h8000_0000, 3'b010);
    apply("R7", 32'd500, 32'd123, 3'b110);
    apply("R7 borrow", 32'd0, 32'd1, 3'b110);
    apply("R7 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
  endtask

  task automatic t_reserved;
    apply("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    apply("R4", 32'h1357_9BDF, 32'h0000_0001, 3'b011);
  endtask

  task automatic t_slt;
    apply("R8 25<32", 32'd25, 32'd32, 3'b111);
    check("R8 literal", y, 32'h0000_0001);
    apply("R8 32<25", 32'd32, 32'd25, 3'b111);
    apply("R8 equal", 32'd77, 32'd77, 3'b111);
    apply("R8 neg", 32'hFFFF_FFF0, 32'd3, 3'b111);
    apply("R9 ovf low", 32'h8000_0000, 32'h0000_0001, 3'b111);
    check("R9 literal low", y, 32'h0000_0000);
    apply("R9 ovf high", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
    check("R9 literal high", y, 32'h0000_0001);
  endtask

  // Change inputs twice inside one clock phase; the result tracks each without an edge.
  task automatic t_comb;
    @(posedge clk);
    a = 32'd7; b = 32'd9; fn = 3'b010;
    #1;
    check("R11 first", y, 32'd16);
    fn = 3'b110;
    #1;
    check("R11 second", y, 32'hFFFF_FFFE);
    b = 32'd7;
    #1;
    check("R11 zero", {{(N-1){1'b0}}, zero}, {{(N-1){1'b0}}, 1'b1});
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_logic();
    t_arith();
    t_reserved();
    t_slt();
    t_comb();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule